// File: doc/BRIEF.md
# Exception Entry State Update Unit

This unit holds the exception-related control registers of a small RISC core and rewrites them in the single clock cycle in which the core takes an exception or interrupt. On that edge it records several things:

- the return address and a copy of the pre-exception status;
- the cause code and the faulting address;
- for translation faults, the faulting page number and one fault-kind flag.

It also forces the status word into a safe state: supervisor mode, interrupts off unless nesting is allowed, and the busy flag set when an MMU is fitted.

Three live configuration inputs select optional behaviour: MMU present, shadow register sets present, and automatic nested interrupts. Fields that belong to an absent option read as zero and are never written. Software reaches every register through one write port and one combinational read port. When software writes a register in the same cycle that the hardware updates it, the hardware value wins.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset every readable register returns 0 and `status_o` is 0.
- R2: On an entry edge the return-address register (index 2) becomes `pc_i + 4`.
- R3: On an entry edge the saved-status register (index 1) becomes the status value as read just before that edge.
- R4: Status bit 0 (interrupt enable) is cleared on entry when `cfg_nest_i` is 0 and keeps its value when `cfg_nest_i` is 1.
- R5: Status bit 1 (user mode) is cleared on entry. Status bit 2 (handler busy) is set on entry when `cfg_mmu_i` is 1.
- R6: With `cfg_shadow_i` = 1, an entry loads status bits [7:4] (current register set) from `req_set_i`. The same entry loads the shadow-status register (index 3) with the pre-entry status, with bit 31 set only when `req_set_i` differs from the pre-entry bits [7:4]. With `cfg_shadow_i` = 0, status bits [7:4] and register 3 read 0, and register 3 is not written.
- R7: The cause register (index 4, bits [4:0]) takes `exc_code_i` on entry, except for code 1 (external interrupt), which leaves it unchanged.
- R8: The bad-address register (index 5) takes `fault_addr_i` on any entry whose code is not 1, and is unchanged on code 1.
- R9: With `cfg_mmu_i` = 1, any code with bit 4 set is a translation fault. Such an entry writes `fault_addr_i[31:12]` into bits [31:12] of register 6. It also writes flag bits [3:0] of register 6, one-hot or zero:
  - bit 0 for code 16 (data access);
  - bit 1 for code 17 (double miss);
  - bit 2 for code 18 (permission);
  - bit 3 for code 19 (bad virtual address);
  - all flags zero for codes 20 to 31.
- R10: With `cfg_mmu_i` = 0, status bit 2 and register 6 read 0, and no code changes the page number or flags.
- R11: In an entry cycle, a software write to a register that the entry updates is lost. A software write to a register that the entry leaves alone takes effect.
- R12: A software write stores the following:
  - index 0 and index 1: only bits 0, 1, bit 2 when the MMU is present, and bits [7:4] when shadow sets are present;
  - index 2 and index 5: the full word;
  - index 4: bits [4:0];
  - index 6: bits [31:12] only, and only when the MMU is present. The flags cannot be written by software.
  - Index 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| take_exc_i | input | 1 | Exception or interrupt taken this cycle |
| exc_code_i | input | 5 | Exception kind code |
| pc_i | input | 32 | Address of the instruction executing at entry |
| fault_addr_i | input | 32 | Faulting address |
| req_set_i | input | 4 | Register set requested for the handler |
| cfg_mmu_i | input | 1 | MMU present |
| cfg_shadow_i | input | 1 | Shadow register sets present |
| cfg_nest_i | input | 1 | Automatic nested interrupts allowed |
| sw_we_i | input | 1 | Software write strobe |
| sw_addr_i | input | 3 | Register index for read and write |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Read data of the indexed register |
| status_o | output | 32 | Current status view |

## Verification
The assertions check on every cycle the values each entry must leave behind:

- the return address;
- the interrupt-enable, user-mode and busy bits;
- the register-set load;
- the cause and bad-address loads, and the cause hold on external interrupts;
- the one-hot-or-zero flag field;
- the frozen flags when no MMU is fitted.

Only the bench scenarios show the rest:

- the exact saved and shadow status words, including the differ flag in both polarities;
- the read masks as the option inputs change;
- which side wins on same-cycle software writes;
- the write masks of each register index.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    REG_STATUS  = 3'd0,
    REG_SAVED   = 3'd1,
    REG_RET     = 3'd2,
    REG_SHADOW  = 3'd3,
    REG_CAUSE   = 3'd4,
    REG_BADADDR = 3'd5,
    REG_TLB     = 3'd6
  } reg_idx_e;

  localparam int IE_BIT    = 0;
  localparam int UM_BIT    = 1;
  localparam int EH_BIT    = 2;
  localparam int CRS_LSB   = 4;
  localparam int SDIFF_BIT = 31;

  localparam int CODE_W        = 5;
  localparam int FLAG_W        = 4;
  localparam int TLB_CLASS_BIT = 4;
  localparam int CODE_EXT_IRQ  = 1;
  localparam int CODE_TLB_BASE = 16;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              cfg_mmu_i,
  output logic              is_irq_o,
  output logic              is_tlb_o,
  output logic [FLAG_W-1:0] flags_o
);
  assign is_irq_o = (code_i == CODE_W'(CODE_EXT_IRQ));
  // translation faults cannot occur without an MMU
  assign is_tlb_o = cfg_mmu_i & code_i[TLB_CLASS_BIT];

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    assign flags_o[i] = is_tlb_o && (code_i == CODE_W'(CODE_TLB_BASE + i));
  end
endmodule

// File: rtl/exc_cfg_mask.sv
module exc_cfg_mask
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SET_W = 4
) (
  input  logic            cfg_mmu_i,
  input  logic            cfg_shadow_i,
  output logic [XLEN-1:0] stat_mask_o
);
  always_comb begin
    stat_mask_o                    = '0;
    stat_mask_o[IE_BIT]            = 1'b1;
    stat_mask_o[UM_BIT]            = 1'b1;
    stat_mask_o[EH_BIT]            = cfg_mmu_i;
    stat_mask_o[CRS_LSB +: SET_W]  = {SET_W{cfg_shadow_i}};
  end
endmodule

// File: rtl/exc_status_next.sv
module exc_status_next
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SET_W = 4
) (
  input  logic [XLEN-1:0]  status_view_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic             cfg_mmu_i,
  input  logic             cfg_shadow_i,
  input  logic             cfg_nest_i,
  output logic [XLEN-1:0]  status_nx_o,
  output logic [XLEN-1:0]  shadow_nx_o
);
  logic set_differs;
  assign set_differs = (req_set_i != status_view_i[CRS_LSB +: SET_W]);

  always_comb begin
    status_nx_o         = status_view_i;
    status_nx_o[IE_BIT] = cfg_nest_i & status_view_i[IE_BIT];
    status_nx_o[UM_BIT] = 1'b0;
    status_nx_o[EH_BIT] = cfg_mmu_i;
    if (cfg_shadow_i) status_nx_o[CRS_LSB +: SET_W] = req_set_i;
    shadow_nx_o            = status_view_i;
    shadow_nx_o[SDIFF_BIT] = cfg_shadow_i & set_differs;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SET_W      = 4,
  parameter int PAGE_BYTES = 4096,
  parameter int RET_STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_exc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic [SET_W-1:0]  req_set_i,
  input  logic              cfg_mmu_i,
  input  logic              cfg_shadow_i,
  input  logic              cfg_nest_i,
  input  logic              sw_we_i,
  input  logic [2:0]        sw_addr_i,
  input  logic [XLEN-1:0]   sw_wdata_i,
  output logic [XLEN-1:0]   sw_rdata_o,
  output logic [XLEN-1:0]   status_o
);
  localparam int VPN_LSB = $clog2(PAGE_BYTES);
  localparam int VPN_W   = XLEN - VPN_LSB;
  localparam int PAD_W   = VPN_LSB - FLAG_W;

  logic [XLEN-1:0]   status_q, saved_q, ret_q, shadow_q, badaddr_q;
  logic [CODE_W-1:0] cause_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [FLAG_W-1:0] flags_q;

  logic [XLEN-1:0]   stat_mask, status_view, shadow_mask;
  logic [XLEN-1:0]   status_nx, shadow_nx;
  logic              is_irq, is_tlb;
  logic [FLAG_W-1:0] flags_nx;

  exc_classify u_class (
    .code_i    (exc_code_i),
    .cfg_mmu_i (cfg_mmu_i),
    .is_irq_o  (is_irq),
    .is_tlb_o  (is_tlb),
    .flags_o   (flags_nx)
  );

  exc_cfg_mask #(.XLEN(XLEN), .SET_W(SET_W)) u_mask (
    .cfg_mmu_i    (cfg_mmu_i),
    .cfg_shadow_i (cfg_shadow_i),
    .stat_mask_o  (stat_mask)
  );

  assign status_view = status_q & stat_mask;
  assign shadow_mask = stat_mask | (XLEN'(1) << SDIFF_BIT);

  exc_status_next #(.XLEN(XLEN), .SET_W(SET_W)) u_next (
    .status_view_i (status_view),
    .req_set_i     (req_set_i),
    .cfg_mmu_i     (cfg_mmu_i),
    .cfg_shadow_i  (cfg_shadow_i),
    .cfg_nest_i    (cfg_nest_i),
    .status_nx_o   (status_nx),
    .shadow_nx_o   (shadow_nx)
  );

  logic wr_status, wr_saved, wr_ret, wr_shadow, wr_cause, wr_bad, wr_tlb;
  assign wr_status = sw_we_i && (sw_addr_i == REG_STATUS);
  assign wr_saved  = sw_we_i && (sw_addr_i == REG_SAVED);
  assign wr_ret    = sw_we_i && (sw_addr_i == REG_RET);
  assign wr_shadow = sw_we_i && (sw_addr_i == REG_SHADOW) && cfg_shadow_i;
  assign wr_cause  = sw_we_i && (sw_addr_i == REG_CAUSE);
  assign wr_bad    = sw_we_i && (sw_addr_i == REG_BADADDR);
  assign wr_tlb    = sw_we_i && (sw_addr_i == REG_TLB) && cfg_mmu_i;

  logic hw_fault, hw_shadow, hw_tlb;
  assign hw_fault  = take_exc_i && !is_irq;
  assign hw_shadow = take_exc_i && cfg_shadow_i;
  assign hw_tlb    = take_exc_i && is_tlb;

  // hardware entry has priority per register over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= '0;
      saved_q   <= '0;
      ret_q     <= '0;
      shadow_q  <= '0;
      cause_q   <= '0;
      badaddr_q <= '0;
      vpn_q     <= '0;
      flags_q   <= '0;
    end else begin
      if (take_exc_i)     status_q <= status_nx;
      else if (wr_status) status_q <= sw_wdata_i & stat_mask;

      if (take_exc_i)    saved_q <= status_view;
      else if (wr_saved) saved_q <= sw_wdata_i & stat_mask;

      if (take_exc_i)  ret_q <= pc_i + XLEN'(RET_STEP);
      else if (wr_ret) ret_q <= sw_wdata_i;

      if (hw_shadow)      shadow_q <= shadow_nx;
      else if (wr_shadow) shadow_q <= sw_wdata_i & shadow_mask;

      if (hw_fault)      cause_q <= exc_code_i;
      else if (wr_cause) cause_q <= sw_wdata_i[CODE_W-1:0];

      if (hw_fault)    badaddr_q <= fault_addr_i;
      else if (wr_bad) badaddr_q <= sw_wdata_i;

      if (hw_tlb) begin
        vpn_q   <= fault_addr_i[XLEN-1:VPN_LSB];
        flags_q <= flags_nx;
      end else if (wr_tlb) begin
        vpn_q   <= sw_wdata_i[XLEN-1:VPN_LSB];
      end
    end
  end

  assign status_o = status_view;

  always_comb begin
    unique case (sw_addr_i)
      REG_STATUS:  sw_rdata_o = status_view;
      REG_SAVED:   sw_rdata_o = saved_q & stat_mask;
      REG_RET:     sw_rdata_o = ret_q;
      REG_SHADOW:  sw_rdata_o = cfg_shadow_i ? (shadow_q & shadow_mask) : '0;
      REG_CAUSE:   sw_rdata_o = XLEN'(cause_q);
      REG_BADADDR: sw_rdata_o = badaddr_q;
      REG_TLB:     sw_rdata_o = cfg_mmu_i ? {vpn_q, {PAD_W{1'b0}}, flags_q} : '0;
      default:     sw_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int SET_W    = 4,
  parameter int RET_STEP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              take_exc_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   fault_addr_i,
  input logic [SET_W-1:0]  req_set_i,
  input logic              cfg_mmu_i,
  input logic              cfg_shadow_i,
  input logic              cfg_nest_i,
  input logic              sw_we_i,
  input logic [2:0]        sw_addr_i,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   ret_q,
  input logic [XLEN-1:0]   badaddr_q,
  input logic [CODE_W-1:0] cause_q,
  input logic [FLAG_W-1:0] flags_q
);
  logic is_irq;
  assign is_irq = (exc_code_i == CODE_W'(CODE_EXT_IRQ));

  p_ret_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i |=> ret_q == $past(pc_i) + XLEN'(RET_STEP));

  p_ie_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i && !cfg_nest_i |=> !status_o[IE_BIT]);

  p_ie_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i && cfg_nest_i |=> status_o[IE_BIT] == $past(status_o[IE_BIT]));

  p_user_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i |=> !status_o[UM_BIT]);

  p_busy_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i && cfg_mmu_i |=> (!cfg_mmu_i || status_o[EH_BIT]));

  p_set_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i && cfg_shadow_i |=>
      (!cfg_shadow_i || status_o[CRS_LSB +: SET_W] == $past(req_set_i)));

  p_cause_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i && !is_irq |=> cause_q == $past(exc_code_i));

  p_cause_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i && is_irq && !(sw_we_i && sw_addr_i == REG_CAUSE) |=> $stable(cause_q));

  p_badaddr_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_exc_i && !is_irq |=> badaddr_q == $past(fault_addr_i));

  p_flags_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_q));

  p_flags_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mmu_i |=> $stable(flags_q));
endmodule

bind exc_entry_unit exc_entry_unit_chk #(.XLEN(XLEN), .SET_W(SET_W), .RET_STEP(RET_STEP)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .take_exc_i   (take_exc_i),
  .exc_code_i   (exc_code_i),
  .pc_i         (pc_i),
  .fault_addr_i (fault_addr_i),
  .req_set_i    (req_set_i),
  .cfg_mmu_i    (cfg_mmu_i),
  .cfg_shadow_i (cfg_shadow_i),
  .cfg_nest_i   (cfg_nest_i),
  .sw_we_i      (sw_we_i),
  .sw_addr_i    (sw_addr_i),
  .status_o     (status_o),
  .ret_q        (ret_q),
  .badaddr_q    (badaddr_q),
  .cause_q      (cause_q),
  .flags_q      (flags_q)
);

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_exc = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] pc = '0, fault_addr = '0;
  logic [3:0]  req_set = '0;
  logic        cfg_mmu = 1'b0, cfg_shadow = 1'b0, cfg_nest = 1'b0;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata, status_o;

  int checks = 0, errors = 0;

  // reference state
  logic [31:0] m_status = '0, m_saved = '0, m_ret = '0, m_shadow = '0, m_bad = '0;
  logic [4:0]  m_cause = '0;
  logic [19:0] m_vpn = '0;
  logic [3:0]  m_flags = '0;

  always #5 clk = ~clk;

  exc_entry_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .take_exc_i(take_exc), .exc_code_i(exc_code),
    .pc_i(pc), .fault_addr_i(fault_addr), .req_set_i(req_set),
    .cfg_mmu_i(cfg_mmu), .cfg_shadow_i(cfg_shadow), .cfg_nest_i(cfg_nest),
    .sw_we_i(sw_we), .sw_addr_i(sw_addr), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .status_o(status_o)
  );

  function automatic logic [31:0] smask(input logic mmu, input logic sh);
    return 32'h3 | (mmu ? 32'h4 : 32'h0) | (sh ? 32'hF0 : 32'h0);
  endfunction

  function automatic logic [31:0] expect_rd(input int a);
    case (a)
      0: return m_status & smask(cfg_mmu, cfg_shadow);
      1: return m_saved & smask(cfg_mmu, cfg_shadow);
      2: return m_ret;
      3: return cfg_shadow ? (m_shadow & (smask(cfg_mmu, 1'b1) | 32'h8000_0000)) : 32'h0;
      4: return {27'b0, m_cause};
      5: return m_bad;
      6: return cfg_mmu ? {m_vpn, 8'h0, m_flags} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reg_tag(input int a);
    case (a)
      0: return "R5"; 1: return "R3"; 2: return "R2"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R9"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string ctx,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, ctx, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    sw_addr = 3'(a);
    #1 v = sw_rdata;
  endtask

  task automatic check_regs(input string ctx, input string req_override);
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk(v === expect_rd(a), (req_override != "") ? req_override : reg_tag(a),
          ctx, v, expect_rd(a));
    end
    chk(status_o === expect_rd(0), (req_override != "") ? req_override : "R4",
        {ctx, " status_o"}, status_o, expect_rd(0));
  endtask

  // drive one cycle, advance the reference model across that edge
  task automatic apply(input bit take, input logic [4:0] code, input logic [31:0] p,
                       input logic [31:0] fa, input logic [3:0] rs, input bit mmu,
                       input bit sh, input bit nest, input bit we, input logic [2:0] addr,
                       input logic [31:0] wd);
    logic [31:0] pre, n_status, n_saved, n_ret, n_shadow, n_bad;
    logic [4:0]  n_cause;
    logic [19:0] n_vpn;
    logic [3:0]  n_flags;
    @(negedge clk);
    take_exc = take; exc_code = code; pc = p; fault_addr = fa; req_set = rs;
    cfg_mmu = mmu; cfg_shadow = sh; cfg_nest = nest;
    sw_we = we; sw_addr = addr; sw_wdata = wd;
    pre = m_status & smask(mmu, sh);
    n_status = m_status; n_saved = m_saved; n_ret = m_ret; n_shadow = m_shadow;
    n_bad = m_bad; n_cause = m_cause; n_vpn = m_vpn; n_flags = m_flags;
    if (we) begin
      case (addr)
        3'd0: n_status = wd & smask(mmu, sh);
        3'd1: n_saved = wd & smask(mmu, sh);
        3'd2: n_ret = wd;
        3'd3: if (sh) n_shadow = wd & (smask(mmu, sh) | 32'h8000_0000);
        3'd4: n_cause = wd[4:0];
        3'd5: n_bad = wd;
        3'd6: if (mmu) n_vpn = wd[31:12];
        default: ;
      endcase
    end
    if (take) begin
      n_status = pre;
      if (!nest) n_status[0] = 1'b0;
      n_status[1] = 1'b0;
      n_status[2] = mmu;
      if (sh) n_status[7:4] = rs;
      n_saved = pre;
      n_ret = p + 32'd4;
      if (sh) begin
        n_shadow = pre;
        n_shadow[31] = (rs != pre[7:4]);
      end
      if (code != 5'd1) begin
        n_cause = code;
        n_bad = fa;
      end
      if (mmu && code >= 5'd16) begin
        n_vpn = fa[31:12];
        case (code)
          5'd16: n_flags = 4'b0001;
          5'd17: n_flags = 4'b0010;
          5'd18: n_flags = 4'b0100;
          5'd19: n_flags = 4'b1000;
          default: n_flags = 4'b0000;
        endcase
      end
    end
    @(posedge clk);
    #1;
    m_status = n_status; m_saved = n_saved; m_ret = n_ret; m_shadow = n_shadow;
    m_bad = n_bad; m_cause = n_cause; m_vpn = n_vpn; m_flags = n_flags;
    take_exc = 1'b0; sw_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 check_regs("reset", "R1");

    // R12: software write of status with both options present
    apply(0, 0, 0, 0, 0, 1, 1, 0, 1, 3'd0, 32'hFFFF_FF53);
    check_regs("sw status write", "R12");
    rd(0, v); chk(v === 32'h53, "R12", "status mask", v, 32'h53);

    // plain exception, same register set requested
    apply(1, 5'd4, 32'h100, 32'hDEAD_0123, 4'd5, 1, 1, 0, 0, 0, 0);
    check_regs("exc code 4", "");
    rd(2, v); chk(v === 32'h104, "R2", "return address", v, 32'h104);
    rd(1, v); chk(v === 32'h53, "R3", "saved status", v, 32'h53);
    rd(3, v); chk(v[31] === 1'b0, "R6", "same set differ bit", {31'b0, v[31]}, 32'h0);
    chk(status_o === 32'h54, "R4", "ie and um cleared, busy set", status_o, 32'h54);

    // nested interrupts allowed, different set requested
    apply(0, 0, 0, 0, 0, 1, 1, 1, 1, 3'd0, 32'h51);
    apply(1, 5'd7, 32'h180, 32'h0000_4444, 4'd2, 1, 1, 1, 0, 0, 0);
    check_regs("nested entry", "");
    chk(status_o[0] === 1'b1, "R4", "ie kept", {31'b0, status_o[0]}, 32'h1);
    rd(3, v); chk(v[31] === 1'b1, "R6", "differ bit", {31'b0, v[31]}, 32'h1);

    // external interrupt leaves cause and bad address alone
    apply(1, 5'd1, 32'h200, 32'h0000_1234, 4'd2, 1, 1, 0, 0, 0, 0);
    check_regs("ext irq", "");
    rd(4, v); chk(v === 32'd7, "R7", "cause held on irq", v, 32'd7);
    rd(5, v); chk(v === 32'h0000_4444, "R8", "bad addr held on irq", v, 32'h0000_4444);

    // translation fault kinds
    for (int c = 16; c <= 21; c++) begin
      apply(1, 5'(c), 32'h300, {20'(c * 3), 12'hABC}, 4'd1, 1, 1, 0, 0, 0, 0);
      check_regs("tlb fault", "");
      rd(6, v);
      chk(v === {20'(c * 3), 8'h0, (c < 20) ? 4'(1 << (c - 16)) : 4'h0}, "R9", "flags and vpn",
          v, {20'(c * 3), 8'h0, (c < 20) ? 4'(1 << (c - 16)) : 4'h0});
    end

    // no MMU: translation code has no effect on page number or flags
    apply(1, 5'd17, 32'h400, 32'hFFFF_F000, 4'd1, 0, 1, 0, 0, 0, 0);
    check_regs("no mmu", "");
    rd(6, v); chk(v === 32'h0, "R10", "tlb reads zero", v, 32'h0);
    chk(status_o[2] === 1'b0, "R10", "busy reads zero", {31'b0, status_o[2]}, 32'h0);
    apply(0, 0, 0, 0, 0, 0, 1, 0, 1, 3'd6, 32'h1234_5000);
    apply(1, 5'd4, 32'h404, 32'h0, 4'd1, 1, 1, 0, 0, 0, 0);
    rd(6, v); chk(v === {20'(21 * 3), 12'h0}, "R10", "tlb unchanged", v, {20'(21 * 3), 12'h0});

    // no shadow sets
    apply(1, 5'd5, 32'h500, 32'h0, 4'd9, 1, 0, 0, 1, 3'd3, 32'hFFFF_FFFF);
    check_regs("no shadow", "");
    rd(3, v); chk(v === 32'h0, "R6", "shadow reads zero", v, 32'h0);

    // same-cycle software writes
    apply(1, 5'd3, 32'h600, 32'h0, 4'd0, 1, 1, 0, 1, 3'd2, 32'h0000_FFFF);
    rd(2, v); chk(v === 32'h604, "R11", "hw wins on return address", v, 32'h604);
    apply(1, 5'd1, 32'h700, 32'h0, 4'd0, 1, 1, 0, 1, 3'd4, 32'd9);
    rd(4, v); chk(v === 32'd9, "R11", "sw cause write during irq", v, 32'd9);
    check_regs("same cycle", "");

    // random traffic
    for (int i = 0; i < 300; i++) begin
      apply(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), $urandom, $urandom,
            4'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
            1'($urandom), 1'($urandom), 3'($urandom), $urandom);
      check_regs("random", "");
    end

    finish_run();
  end
endmodule